// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This unit holds the inter-processor interrupt state for a small cluster of CPUs and sits next to the main interrupt controller. Each CPU has two IPI kinds, "other" and "self". Each kind has its own pending flag and mask bit. Any CPU can raise "other" on any group of CPUs with one write that carries one bit per target. A CPU can also raise "self" on itself. Each CPU clears its own flags and mask bits through its local registers.

Every CPU gets a level interrupt output and a 32-bit event word. The word names the highest-priority IPI that is pending and unmasked, in the controller's type/number encoding. The event can also be read over the register bus. That read masks the reported IPI for the reader, so the handler cannot be re-entered until software unmasks it again.

The bus has `NUM_PORTS` independent 32-bit ports. On each port a `cpu_id` sideband selects the local view of the CPU making the access. Accesses that arrive on different ports in the same cycle all take effect together.

Top module: `ipi_unit`

## Requirements
- R1: After reset every pending flag is clear and both masks of every CPU are set. Every event word is 0, every `ipi_irq_o` is low, and the mask view reads 0x8000_0001.
- R2: A write to the send register (word 1) sets the "other" pending flag on CPU i for each set bit i below `NUM_CPUS`. Bit 31 sets the "self" pending flag of the writing CPU. One write may target several CPUs.
- R3: Send bits from `NUM_CPUS` up to 30 have no effect. Any access whose `cpu_id` is `NUM_CPUS` or more has no effect and reads 0.
- R4: A write to the acknowledge register (word 2) clears the writer's own flags: bit 0 clears "other" and bit 31 clears "self". Flags of other CPUs are unchanged.
- R5: Mask-set (word 3) and mask-clear (word 4) act on the writer's own masks, with bit 0 for "other" and bit 31 for "self". A 1 sets or clears the bit and a 0 leaves it unchanged. A read of word 3 or word 4 returns the mask in the same two bit positions.
- R6: The event word is 0x0004_0001 for "other", 0x0004_0002 for "self" and 0 when no IPI is both pending and unmasked. A read of word 0 returns the reader's event word.
- R7: When both IPIs are pending and unmasked, the event reports "other".
- R8: Reading word 0 sets, at the end of that cycle, the mask bit of the IPI it returned, for the reading CPU only. A read that returns 0 changes nothing.
- R9: `ipi_irq_o[i]` is high exactly when CPU i has an IPI that is pending and unmasked, that is, when its event word is nonzero.
- R10: If a send and an acknowledge hit the same flag in the same cycle on different ports, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PORTS | Access strobe per port |
| we_i | input | NUM_PORTS | 1 = write, 0 = read |
| addr_i | input | NUM_PORTS x 3 | Word index: 0 event, 1 send, 2 acknowledge, 3 mask set, 4 mask clear |
| wdata_i | input | NUM_PORTS x 32 | Write data |
| cpu_id_i | input | NUM_PORTS x 5 | Index of the CPU making the access |
| rdata_o | output | NUM_PORTS x 32 | Read data, valid in the cycle of the read |
| ipi_irq_o | output | NUM_CPUS | Per-CPU IPI interrupt level |
| event_o | output | NUM_CPUS x 32 | Per-CPU event word |

## Verification
The bench builds the unit with four CPUs and two ports. With four CPUs, send bits 4 to 30 and `cpu_id` values 4 to 31 fall outside the configured range, so the checks can catch a design that wraps or aliases such accesses onto a real CPU. With two ports, a send on one port and an acknowledge on the other can hit the same flag in the same cycle. That is the only way the send-wins rule can be exercised at all.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_W     = 5;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int MAX_CPUS = 31;
  localparam int BIT_OTH  = 0;
  localparam int BIT_SLF  = 31;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVENT = 3'd0,
    REG_SEND  = 3'd1,
    REG_ACK   = 3'd2,
    REG_MSET  = 3'd3,
    REG_MCLR  = 3'd4
  } reg_e;

  localparam logic [15:0] EV_TYPE_IPI = 16'd4;
  localparam logic [DATA_W-1:0] EV_OTHER = {EV_TYPE_IPI, 16'd1};
  localparam logic [DATA_W-1:0] EV_SELF  = {EV_TYPE_IPI, 16'd2};

  // pair index 0 = other, 1 = self
  function automatic logic [1:0] pick_pair(logic [DATA_W-1:0] w);
    return {w[BIT_SLF], w[BIT_OTH]};
  endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [ID_W-1:0]          cpu_id_i,
  output logic                     rd_ok_o,
  output logic [NUM_CPUS-1:0]      send_oth_o,
  output logic [NUM_CPUS-1:0]      send_slf_o,
  output logic [NUM_CPUS-1:0][1:0] ack_o,
  output logic [NUM_CPUS-1:0][1:0] mset_o,
  output logic [NUM_CPUS-1:0][1:0] mclr_o,
  output logic [NUM_CPUS-1:0]      evt_rd_o
);
  logic       hit;
  logic [1:0] pair;
  logic       unused_wdata;

  assign hit          = req_i && (32'(cpu_id_i) < NUM_CPUS);
  assign pair         = pick_pair(wdata_i);
  assign rd_ok_o      = hit && !we_i;
  assign unused_wdata = &{1'b0, wdata_i};

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      logic sel;
      sel           = hit && (cpu_id_i == ID_W'(c));
      send_oth_o[c] = hit && we_i && (addr_i == REG_SEND) && wdata_i[c];
      send_slf_o[c] = sel && we_i && (addr_i == REG_SEND) && wdata_i[BIT_SLF];
      ack_o[c]      = (sel && we_i && addr_i == REG_ACK)  ? pair : 2'b00;
      mset_o[c]     = (sel && we_i && addr_i == REG_MSET) ? pair : 2'b00;
      mclr_o[c]     = (sel && we_i && addr_i == REG_MCLR) ? pair : 2'b00;
      evt_rd_o[c]   = sel && !we_i && (addr_i == REG_EVENT);
    end
  end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_oth_i,
  input  logic              send_slf_i,
  input  logic [1:0]        ack_i,
  input  logic [1:0]        mset_i,
  input  logic [1:0]        mclr_i,
  input  logic              evt_rd_i,
  output logic [1:0]        pend_o,
  output logic [1:0]        mask_o,
  output logic [DATA_W-1:0] event_o,
  output logic              irq_o
);
  logic [1:0] pend_q, mask_q, pend_d, mask_d, live, rd_mask;

  assign live = pend_q & ~mask_q;

  always_comb begin
    rd_mask = 2'b00;
    if (evt_rd_i) begin
      if (live[0])      rd_mask[0] = 1'b1;
      else if (live[1]) rd_mask[1] = 1'b1;
    end
    // send after ack: a colliding send survives
    pend_d = (pend_q & ~ack_i) | {send_slf_i, send_oth_i};
    // set after clear: masking wins a collision
    mask_d = (mask_q & ~mclr_i) | mset_i | rd_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 2'b00;
      mask_q <= 2'b11;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign event_o = live[0] ? EV_OTHER : (live[1] ? EV_SELF : '0);
  assign irq_o   = |live;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_i,
  input  logic [NUM_PORTS-1:0]              we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_i,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]    cpu_id_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
  output logic [NUM_CPUS-1:0]               ipi_irq_o,
  output logic [NUM_CPUS-1:0][DATA_W-1:0]   event_o
);
  logic [NUM_PORTS-1:0]                     rd_ok_p;
  logic [NUM_PORTS-1:0][NUM_CPUS-1:0]       send_oth_p, send_slf_p, evt_rd_p;
  logic [NUM_PORTS-1:0][NUM_CPUS-1:0][1:0]  ack_p, mset_p, mclr_p;

  logic [NUM_CPUS-1:0]      send_oth, send_slf, evt_rd;
  logic [NUM_CPUS-1:0][1:0] ack, mset, mclr;
  logic [NUM_CPUS-1:0][1:0] pend_w, mask_w;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ipi_port_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
      .req_i      (req_i[p]),
      .we_i       (we_i[p]),
      .addr_i     (addr_i[p]),
      .wdata_i    (wdata_i[p]),
      .cpu_id_i   (cpu_id_i[p]),
      .rd_ok_o    (rd_ok_p[p]),
      .send_oth_o (send_oth_p[p]),
      .send_slf_o (send_slf_p[p]),
      .ack_o      (ack_p[p]),
      .mset_o     (mset_p[p]),
      .mclr_o     (mclr_p[p]),
      .evt_rd_o   (evt_rd_p[p])
    );
  end

  always_comb begin
    send_oth = '0;
    send_slf = '0;
    evt_rd   = '0;
    ack      = '0;
    mset     = '0;
    mclr     = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      send_oth |= send_oth_p[p];
      send_slf |= send_slf_p[p];
      evt_rd   |= evt_rd_p[p];
      ack      |= ack_p[p];
      mset     |= mset_p[p];
      mclr     |= mclr_p[p];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    ipi_cpu_slice u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .send_oth_i (send_oth[c]),
      .send_slf_i (send_slf[c]),
      .ack_i      (ack[c]),
      .mset_i     (mset[c]),
      .mclr_i     (mclr[c]),
      .evt_rd_i   (evt_rd[c]),
      .pend_o     (pend_w[c]),
      .mask_o     (mask_w[c]),
      .event_o    (event_o[c]),
      .irq_o      (ipi_irq_o[c])
    );
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rdata_o[p] = '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (rd_ok_p[p] && cpu_id_i[p] == ID_W'(c)) begin
          case (addr_i[p])
            REG_EVENT:          rdata_o[p] = event_o[c];
            REG_MSET, REG_MCLR: rdata_o[p] = {mask_w[c][1], 30'd0, mask_w[c][0]};
            default:            rdata_o[p] = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_PORTS-1:0]              req_i,
  input logic [NUM_PORTS-1:0]              we_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_i,
  input logic [NUM_PORTS-1:0][ID_W-1:0]    cpu_id_i,
  input logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
  input logic [NUM_CPUS-1:0]               ipi_irq_o,
  input logic [NUM_CPUS-1:0][DATA_W-1:0]   event_o,
  input logic [NUM_CPUS-1:0][1:0]          pend_i,
  input logic [NUM_CPUS-1:0][1:0]          mask_i
);
  logic [NUM_CPUS-1:0] s_oth, s_slf, a_oth, m_set_oth;

  always_comb begin
    s_oth     = '0;
    s_slf     = '0;
    a_oth     = '0;
    m_set_oth = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        logic wr, own;
        wr  = req_i[p] && we_i[p] && (32'(cpu_id_i[p]) < NUM_CPUS);
        own = wr && (32'(cpu_id_i[p]) == c);
        if (wr && addr_i[p] == REG_SEND && wdata_i[p][c])          s_oth[c] = 1'b1;
        if (own && addr_i[p] == REG_SEND && wdata_i[p][BIT_SLF])   s_slf[c] = 1'b1;
        if (own && addr_i[p] == REG_ACK && wdata_i[p][BIT_OTH])    a_oth[c] = 1'b1;
        if (own && addr_i[p] == REG_MSET && wdata_i[p][BIT_OTH])   m_set_oth[c] = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    assert_send_other_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_oth[c] |=> pend_i[c][0]);
    assert_send_self_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_slf[c] |=> pend_i[c][1]);
    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_oth[c] && !s_oth[c]) |=> !pend_i[c][0]);
    assert_mask_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_set_oth[c] |=> mask_i[c][0]);
    assert_event_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_o[c] == '0) || (event_o[c] == EV_OTHER) || (event_o[c] == EV_SELF));
    assert_other_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[c][0] && !mask_i[c][0]) |-> (event_o[c] == EV_OTHER));
    assert_irq_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ipi_irq_o[c] == (event_o[c] != '0));
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      assert_auto_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i[p] && !we_i[p] && addr_i[p] == REG_EVENT && 32'(cpu_id_i[p]) == c &&
         rdata_o[p] == EV_OTHER) |=> mask_i[c][0]);
    end
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPUS(NUM_CPUS), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .cpu_id_i  (cpu_id_i),
  .rdata_o   (rdata_o),
  .ipi_irq_o (ipi_irq_o),
  .event_o   (event_o),
  .pend_i    (pend_w),
  .mask_i    (mask_w)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int P = 2;
  localparam logic [31:0] EV_OTH = 32'h0004_0001;
  localparam logic [31:0] EV_SLF = 32'h0004_0002;
  localparam logic [2:0] A_EVT = 3'd0, A_SEND = 3'd1, A_ACK = 3'd2, A_MSET = 3'd3, A_MCLR = 3'd4;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [P-1:0]          req_i = '0;
  logic [P-1:0]          we_i = '0;
  logic [P-1:0][2:0]     addr_i = '0;
  logic [P-1:0][31:0]    wdata_i = '0;
  logic [P-1:0][4:0]     cpu_id_i = '0;
  logic [P-1:0][31:0]    rdata_o;
  logic [N-1:0]          ipi_irq_o;
  logic [N-1:0][31:0]    event_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] rd_last;

  ipi_unit #(.NUM_CPUS(N), .NUM_PORTS(P)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cpu_id_i(cpu_id_i), .rdata_o(rdata_o),
    .ipi_irq_o(ipi_irq_o), .event_o(event_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [4:0]  cpu;
    logic [31:0] wdata;
    logic [1:0]  chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 3'd4, 5'd0, 32'h0000_0001, 2'd0, 32'h0,        8'd5},
    '{1'b1, 3'd1, 5'd1, 32'h0000_0001, 2'd0, 32'h0004_0001, 8'd2},
    '{1'b1, 3'd1, 5'd0, 32'h8000_0000, 2'd0, 32'h0004_0001, 8'd5},
    '{1'b1, 3'd4, 5'd0, 32'h8000_0000, 2'd0, 32'h0004_0001, 8'd7},
    '{1'b1, 3'd2, 5'd0, 32'h0000_0001, 2'd0, 32'h0004_0002, 8'd4},
    '{1'b1, 3'd2, 5'd0, 32'h8000_0000, 2'd0, 32'h0,        8'd4},
    '{1'b1, 3'd4, 5'd2, 32'h8000_0001, 2'd2, 32'h0,        8'd5},
    '{1'b1, 3'd1, 5'd3, 32'h0000_0004, 2'd2, 32'h0004_0001, 8'd2},
    '{1'b1, 3'd3, 5'd2, 32'h0000_0001, 2'd2, 32'h0,        8'd5},
    '{1'b1, 3'd4, 5'd2, 32'h0000_0000, 2'd2, 32'h0,        8'd5},
    '{1'b1, 3'd4, 5'd2, 32'h0000_0001, 2'd2, 32'h0004_0001, 8'd5},
    '{1'b1, 3'd2, 5'd3, 32'h0000_0001, 2'd2, 32'h0004_0001, 8'd4},
    '{1'b1, 3'd2, 5'd2, 32'h0000_0001, 2'd2, 32'h0,        8'd4}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_port(input int p, input logic we, input logic [2:0] a,
                          input logic [4:0] cpu, input logic [31:0] d);
    req_i[p] = 1'b1; we_i[p] = we; addr_i[p] = a; cpu_id_i[p] = cpu; wdata_i[p] = d;
  endtask

  task automatic go();
    #1 rd_last = rdata_o[0];
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = '0; we_i = '0;
  endtask

  task automatic acc(input logic we, input logic [2:0] a, input logic [4:0] cpu,
                     input logic [31:0] d);
    set_port(0, we, a, cpu, d);
    go();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int c = 0; c < N; c++) check("1 event", event_o[c], 32'h0);
    check("1 irq", 32'(ipi_irq_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int c = 0; c < N; c++) begin
      acc(1'b0, A_MSET, 5'(c), 32'h0);
      check("1 mask", rd_last, 32'h8000_0001);
    end

    // table walk: writes on port 0, event and irq of one CPU checked afterwards
    foreach (VECS[i]) begin
      acc(VECS[i].we, VECS[i].addr, VECS[i].cpu, VECS[i].wdata);
      check($sformatf("%0d table[%0d]", VECS[i].req, i), event_o[VECS[i].chk], VECS[i].exp);
      check("9 table irq", 32'(ipi_irq_o[VECS[i].chk]), 32'(VECS[i].exp != 0));
    end

    // R3 send bits beyond the CPU count and out-of-range cpu_id are ignored
    acc(1'b1, A_SEND, 5'd1, 32'h7FFF_FFF0);
    check("3 high send cpu0", event_o[0], 32'h0);
    check("3 high send cpu2", event_o[2], 32'h0);
    acc(1'b1, A_MCLR, 5'd5, 32'hFFFF_FFFF);
    acc(1'b0, A_MSET, 5'd1, 32'h0);
    check("3 bad id mask", rd_last, 32'h8000_0001);
    acc(1'b1, A_SEND, 5'd4, 32'h8000_0001);
    check("3 bad id send", event_o[0], 32'h0);
    acc(1'b0, A_MSET, 5'd4, 32'h0);
    check("3 bad id read", rd_last, 32'h0);

    // R7 priority, R6 read encoding, R8 auto-mask
    acc(1'b1, A_SEND, 5'd1, 32'h0000_0001);
    acc(1'b1, A_SEND, 5'd0, 32'h8000_0000);
    check("7 both pending", event_o[0], EV_OTH);
    acc(1'b0, A_EVT, 5'd0, 32'h0);
    check("6 read other", rd_last, EV_OTH);
    check("8 after other read", event_o[0], EV_SLF);
    acc(1'b0, A_MSET, 5'd0, 32'h0);
    check("8 other masked", rd_last, 32'h0000_0001);
    acc(1'b0, A_EVT, 5'd0, 32'h0);
    check("6 read self", rd_last, EV_SLF);
    check("8 after self read", event_o[0], 32'h0);
    check("9 irq low", 32'(ipi_irq_o[0]), 32'h0);
    acc(1'b0, A_EVT, 5'd0, 32'h0);
    check("6 read none", rd_last, 32'h0);
    acc(1'b0, A_MCLR, 5'd0, 32'h0);
    check("8 zero read no change", rd_last, 32'h8000_0001);
    check("8 other cpu mask", event_o[2], 32'h0);
    acc(1'b1, A_ACK, 5'd0, 32'h8000_0001);
    acc(1'b1, A_MCLR, 5'd0, 32'h8000_0001);
    check("4 both acked", event_o[0], 32'h0);

    // R10 send vs ack collision on two ports
    set_port(0, 1'b1, A_SEND, 5'd1, 32'h0000_0004);
    set_port(1, 1'b1, A_ACK, 5'd2, 32'h0000_0001);
    go();
    check("10 other send wins", event_o[2], EV_OTH);
    acc(1'b1, A_ACK, 5'd2, 32'h0000_0001);
    check("4 ack after collision", event_o[2], 32'h0);
    set_port(0, 1'b1, A_SEND, 5'd2, 32'h8000_0000);
    set_port(1, 1'b1, A_ACK, 5'd2, 32'h8000_0000);
    go();
    check("10 self send wins", event_o[2], EV_SLF);
    check("9 irq high", 32'(ipi_irq_o[2]), 32'h1);

    // R2 multi-target send, and two sends in one cycle
    acc(1'b1, A_SEND, 5'd3, 32'h0000_0005);
    check("2 multi cpu0", event_o[0], EV_OTH);
    check("2 multi cpu2", event_o[2], EV_OTH);
    acc(1'b1, A_ACK, 5'd0, 32'h0000_0001);
    acc(1'b1, A_ACK, 5'd2, 32'h8000_0001);
    set_port(0, 1'b1, A_SEND, 5'd1, 32'h0000_0001);
    set_port(1, 1'b1, A_SEND, 5'd3, 32'h0000_0004);
    go();
    check("2 dual cpu0", event_o[0], EV_OTH);
    check("2 dual cpu2", event_o[2], EV_OTH);

    done = 1;
    summary();
    $finish;
  end
endmodule